// File: doc/BRIEF.md
# Cache Bank Request Scheduler

This block is the front-end arbiter for one cache bank. Each cycle it chooses at most one operation for the bank pipeline. It considers three sources in a fixed order: a replay waiting in the miss table, a fill response returning from memory, and the core request inputs. Core inputs that address the same line with the same direction are coalesced into one bank operation. Each input takes a fixed port slot of that operation.

Requests marked as uncached skip the bank entirely. They go out on a bypass channel, and the issuing input index is packed into the low bits of the request tag. When a bypass response returns, the scheduler decodes those low bits to pick the target input and strips them from the tag. When immediate acknowledgements are enabled, an uncached write is acknowledged in the same cycle it is accepted. Two saturating counters record core requests held back by a bank conflict and by a full miss table.

The chosen bank operation is registered, so it appears on the outputs one cycle after the decision. Ready, replay-take, fill-ready, the bypass request and the core responses are combinational.

Top module: `bank_sched`

## Requirements
- R1: When `replay_avail` is high, `replay_take` is high, `fill_ready` is low, no cached core input sees ready, and on the next cycle `breq_kind` is 2 (replay).
- R2: When no replay is pending and `fill_valid` is high, `fill_ready` is high, and on the next cycle `breq_kind` is 1 (fill) with `breq_fill_id` equal to the accepted `fill_id`.
- R3: When the slot is free, the lowest-index valid cached input opens a core operation: it sees ready, and on the next cycle `breq_kind` is 3 (core) with its set, line tag and direction. Port slot `i % PORTS` is marked valid and holds its index and request tag. `breq_kind` 0 means idle, and every port valid bit is 0 whenever the kind is not 3.
- R4: A later cached input is merged into the open core operation, and sees ready, when its set, line tag and direction all match and its port slot is still unused.
- R5: A cached input that meets an open core operation with a different set, tag or direction, or with its port slot already used, is held. It adds one to `stall_bank_cnt`.
- R6: While `mshr_full` is high, a cached read is held and adds one to `stall_mshr_cnt`. A cached write is held in the same way only when WRITE_BACK is 1; in write-through mode (WRITE_BACK=0) it is still accepted.
- R7: Among valid uncached inputs, only the lowest-index one is accepted, and only while `byp_req_ready` is high. It is accepted whatever the bank slot holds. `byp_req_rtag` is `{request tag, input index}`, with the index in the low log2(NI) bits. No uncached request enters the bank operation.
- R8: A `byp_rsp_valid` raises `rsp_valid[k]`, where k is the low log2(NI) bits of `byp_rsp_rtag`. That input's `rsp_rtag` is the remaining upper bits.
- R9: With WRITE_ACK=1, an accepted uncached write raises `rsp_valid` of its own input in the same cycle, carrying its own request tag.
- R10: An uncached write whose acknowledgement would land on the input that a bypass response targets in the same cycle is held. An uncached read on that input is not affected.
- R11: Each stall counter adds the number of inputs held for its reason in a cycle, and stops at all ones.
- R12: After reset, `breq_kind` is 0, `breq_port_vld` is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_valid | input | NI | Per-input request valid |
| core_ready | output | NI | Per-input accept |
| core_write | input | NI | Per-input write flag |
| core_io | input | NI | Per-input uncached flag |
| core_set | input | NI*SET_W | Per-input set index |
| core_line_tag | input | NI*TAG_W | Per-input line tag |
| core_rtag | input | NI*RTAG_W | Per-input request tag |
| replay_avail | input | 1 | Miss table has a replay ready |
| replay_take | output | 1 | Replay consumed this cycle |
| mshr_full | input | 1 | Miss table has no free entry |
| fill_valid | input | 1 | Fill response present |
| fill_id | input | FID_W | Miss-table entry of the fill |
| fill_ready | output | 1 | Fill consumed this cycle |
| breq_kind | output | 2 | Bank operation: 0 idle, 1 fill, 2 replay, 3 core |
| breq_write | output | 1 | Core operation direction |
| breq_set | output | SET_W | Core operation set |
| breq_tag | output | TAG_W | Core operation line tag |
| breq_fill_id | output | FID_W | Fill entry id |
| breq_port_vld | output | PORTS | Port slot valid bits |
| breq_port_src | output | PORTS*IDX_W | Input index per slot |
| breq_port_rtag | output | PORTS*RTAG_W | Request tag per slot |
| byp_req_valid | output | 1 | Bypass request issued |
| byp_req_ready | input | 1 | Bypass channel can accept |
| byp_req_write | output | 1 | Bypass request direction |
| byp_req_set | output | SET_W | Bypass request set |
| byp_req_tag | output | TAG_W | Bypass request line tag |
| byp_req_rtag | output | RTAG_W+IDX_W | Encoded bypass tag |
| byp_rsp_valid | input | 1 | Bypass response present |
| byp_rsp_rtag | input | RTAG_W+IDX_W | Encoded bypass response tag |
| rsp_valid | output | NI | Per-input response valid |
| rsp_rtag | output | NI*RTAG_W | Per-input response tag |
| stall_bank_cnt | output | CNT_W | Saturating bank-conflict stall count |
| stall_mshr_cnt | output | CNT_W | Saturating miss-table stall count |

## Verification
Two things can want the same per-input response lane in one cycle: a returning bypass response and the immediate acknowledgement of a newly accepted uncached write. The bench provokes this by driving a bypass response whose low tag bits name an input that is presenting an uncached write in that same cycle. It then checks that the write stays unaccepted, that the lane carries the decoded response tag, and that an uncached read in the same position goes through. A second overlap is a replay or fill taking the bank slot while cached and uncached core requests are also present. In that case the bench checks that only the uncached request is accepted.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
  typedef enum logic [1:0] {
    BK_NONE   = 2'd0,
    BK_FILL   = 2'd1,
    BK_REPLAY = 2'd2,
    BK_CORE   = 2'd3
  } bank_kind_e;
endpackage

// File: rtl/bsched_select.sv
module bsched_select
  import bsched_pkg::*;
#(
  parameter int NI         = 4,
  parameter int PORTS      = 2,
  parameter int SET_W      = 3,
  parameter int TAG_W      = 4,
  parameter int RTAG_W     = 6,
  parameter bit WRITE_BACK = 1'b0,
  parameter bit WRITE_ACK  = 1'b1,
  localparam int IDX_W     = $clog2(NI),
  localparam int CW        = $clog2(NI + 1)
) (
  input  logic [NI-1:0]          core_valid,
  input  logic [NI-1:0]          core_write,
  input  logic [NI-1:0]          core_io,
  input  logic [NI*SET_W-1:0]    core_set,
  input  logic [NI*TAG_W-1:0]    core_line_tag,
  input  logic [NI*RTAG_W-1:0]   core_rtag,
  input  logic                   replay_avail,
  input  logic                   mshr_full,
  input  logic                   fill_valid,
  input  logic                   byp_req_ready,
  input  logic                   byp_rsp_valid,
  input  logic [IDX_W-1:0]       byp_rsp_idx,
  output logic [NI-1:0]          core_ready,
  output logic                   replay_take,
  output logic                   fill_ready,
  output bank_kind_e             nxt_kind,
  output logic                   nxt_write,
  output logic [SET_W-1:0]       nxt_set,
  output logic [TAG_W-1:0]       nxt_tag,
  output logic [PORTS-1:0]       nxt_pvld,
  output logic [PORTS*IDX_W-1:0] nxt_psrc,
  output logic [PORTS*RTAG_W-1:0] nxt_prtag,
  output logic                   byp_taken,
  output logic [IDX_W-1:0]       byp_idx,
  output logic [CW-1:0]          n_bank_stall,
  output logic [CW-1:0]          n_mshr_stall
);

  logic [NI-1:0] lane_busy;

  // Inputs whose response lane is claimed by a bypass response this cycle.
  always_comb begin
    for (int k = 0; k < NI; k++) begin
      lane_busy[k] = byp_rsp_valid && (byp_rsp_idx == IDX_W'(k));
    end
  end

  // Scan the inputs in ascending index order. The slot is seeded first by
  // a replay, then by a fill.
  always_comb begin
    nxt_kind     = BK_NONE;
    nxt_write    = 1'b0;
    nxt_set      = '0;
    nxt_tag      = '0;
    nxt_pvld     = '0;
    nxt_psrc     = '0;
    nxt_prtag    = '0;
    replay_take  = 1'b0;
    fill_ready   = 1'b0;
    core_ready   = '0;
    byp_taken    = 1'b0;
    byp_idx      = '0;
    n_bank_stall = '0;
    n_mshr_stall = '0;
    if (replay_avail) begin
      nxt_kind    = BK_REPLAY;
      replay_take = 1'b1;
    end else if (fill_valid) begin
      nxt_kind   = BK_FILL;
      fill_ready = 1'b1;
    end
    for (int i = 0; i < NI; i++) begin
      if (core_valid[i]) begin
        if (core_io[i]) begin
          if (!byp_taken && byp_req_ready &&
              !(WRITE_ACK && core_write[i] && lane_busy[i])) begin
            core_ready[i] = 1'b1;
            byp_taken     = 1'b1;
            byp_idx       = IDX_W'(i);
          end
        end else if (nxt_kind == BK_FILL || nxt_kind == BK_REPLAY) begin
          // The slot is taken by a miss-table operation; the input waits.
        end else if ((!core_write[i] || WRITE_BACK) && mshr_full) begin
          n_mshr_stall = n_mshr_stall + 1'b1;
        end else if (nxt_kind == BK_CORE) begin
          if (core_write[i] != nxt_write ||
              core_set[i*SET_W +: SET_W] != nxt_set ||
              core_line_tag[i*TAG_W +: TAG_W] != nxt_tag ||
              nxt_pvld[i % PORTS]) begin
            n_bank_stall = n_bank_stall + 1'b1;
          end else begin
            core_ready[i]                          = 1'b1;
            nxt_pvld[i % PORTS]                    = 1'b1;
            nxt_psrc[(i % PORTS)*IDX_W +: IDX_W]   = IDX_W'(i);
            nxt_prtag[(i % PORTS)*RTAG_W +: RTAG_W] = core_rtag[i*RTAG_W +: RTAG_W];
          end
        end else begin
          nxt_kind                               = BK_CORE;
          nxt_write                              = core_write[i];
          nxt_set                                = core_set[i*SET_W +: SET_W];
          nxt_tag                                = core_line_tag[i*TAG_W +: TAG_W];
          core_ready[i]                          = 1'b1;
          nxt_pvld[i % PORTS]                    = 1'b1;
          nxt_psrc[(i % PORTS)*IDX_W +: IDX_W]   = IDX_W'(i);
          nxt_prtag[(i % PORTS)*RTAG_W +: RTAG_W] = core_rtag[i*RTAG_W +: RTAG_W];
        end
      end
    end
  end

endmodule

// File: rtl/bsched_byp_route.sv
module bsched_byp_route #(
  parameter int NI        = 4,
  parameter int SET_W     = 3,
  parameter int TAG_W     = 4,
  parameter int RTAG_W    = 6,
  parameter bit WRITE_ACK = 1'b1,
  localparam int IDX_W    = $clog2(NI),
  localparam int BT_W     = RTAG_W + IDX_W
) (
  input  logic [NI-1:0]        core_ready,
  input  logic [NI-1:0]        core_write,
  input  logic [NI-1:0]        core_io,
  input  logic [NI*SET_W-1:0]  core_set,
  input  logic [NI*TAG_W-1:0]  core_line_tag,
  input  logic [NI*RTAG_W-1:0] core_rtag,
  input  logic                 byp_taken,
  input  logic [IDX_W-1:0]     byp_idx,
  input  logic                 byp_rsp_valid,
  input  logic [BT_W-1:0]      byp_rsp_rtag,
  output logic                 byp_req_valid,
  output logic                 byp_req_write,
  output logic [SET_W-1:0]     byp_req_set,
  output logic [TAG_W-1:0]     byp_req_tag,
  output logic [BT_W-1:0]      byp_req_rtag,
  output logic [NI-1:0]        rsp_valid,
  output logic [NI*RTAG_W-1:0] rsp_rtag
);

  logic [IDX_W-1:0]  rsp_idx;
  logic [RTAG_W-1:0] rsp_body;

  assign rsp_idx  = byp_rsp_rtag[IDX_W-1:0];
  assign rsp_body = byp_rsp_rtag[BT_W-1:IDX_W];

  // Outgoing request: the input index goes in the low tag bits.
  always_comb begin
    byp_req_valid = byp_taken;
    byp_req_write = core_write[byp_idx];
    byp_req_set   = core_set[byp_idx*SET_W +: SET_W];
    byp_req_tag   = core_line_tag[byp_idx*TAG_W +: TAG_W];
    byp_req_rtag  = {core_rtag[byp_idx*RTAG_W +: RTAG_W], byp_idx};
  end

  // Each response lane is fed by either the decoded bypass response or the
  // immediate write acknowledgement. The scheduler keeps the two from
  // colliding on one lane.
  for (genvar g = 0; g < NI; g++) begin : g_lane
    logic hit, ack;
    assign hit = byp_rsp_valid && (rsp_idx == IDX_W'(g));
    assign ack = WRITE_ACK && core_ready[g] && core_io[g] && core_write[g];
    assign rsp_valid[g] = hit || ack;
    assign rsp_rtag[g*RTAG_W +: RTAG_W] =
      hit ? rsp_body : (ack ? core_rtag[g*RTAG_W +: RTAG_W] : '0);
  end

endmodule

// File: rtl/bsched_satcnt.sv
module bsched_satcnt #(
  parameter int CNT_W = 4,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    sum    = {1'b0, cnt} + (CNT_W + 1)'(inc);
    cnt_d  = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    cnt_en = (inc != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/bank_sched.sv
module bank_sched
  import bsched_pkg::*;
#(
  parameter int NI         = 4,
  parameter int PORTS      = 2,
  parameter int SET_W      = 3,
  parameter int TAG_W      = 4,
  parameter int RTAG_W     = 6,
  parameter int FID_W      = 3,
  parameter int CNT_W      = 4,
  parameter bit WRITE_BACK = 1'b0,
  parameter bit WRITE_ACK  = 1'b1,
  localparam int IDX_W     = $clog2(NI),
  localparam int CW        = $clog2(NI + 1),
  localparam int BT_W      = RTAG_W + IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NI-1:0]           core_valid,
  output logic [NI-1:0]           core_ready,
  input  logic [NI-1:0]           core_write,
  input  logic [NI-1:0]           core_io,
  input  logic [NI*SET_W-1:0]     core_set,
  input  logic [NI*TAG_W-1:0]     core_line_tag,
  input  logic [NI*RTAG_W-1:0]    core_rtag,
  input  logic                    replay_avail,
  output logic                    replay_take,
  input  logic                    mshr_full,
  input  logic                    fill_valid,
  input  logic [FID_W-1:0]        fill_id,
  output logic                    fill_ready,
  output logic [1:0]              breq_kind,
  output logic                    breq_write,
  output logic [SET_W-1:0]        breq_set,
  output logic [TAG_W-1:0]        breq_tag,
  output logic [FID_W-1:0]        breq_fill_id,
  output logic [PORTS-1:0]        breq_port_vld,
  output logic [PORTS*IDX_W-1:0]  breq_port_src,
  output logic [PORTS*RTAG_W-1:0] breq_port_rtag,
  output logic                    byp_req_valid,
  input  logic                    byp_req_ready,
  output logic                    byp_req_write,
  output logic [SET_W-1:0]        byp_req_set,
  output logic [TAG_W-1:0]        byp_req_tag,
  output logic [BT_W-1:0]         byp_req_rtag,
  input  logic                    byp_rsp_valid,
  input  logic [BT_W-1:0]         byp_rsp_rtag,
  output logic [NI-1:0]           rsp_valid,
  output logic [NI*RTAG_W-1:0]    rsp_rtag,
  output logic [CNT_W-1:0]        stall_bank_cnt,
  output logic [CNT_W-1:0]        stall_mshr_cnt
);

  bank_kind_e               nxt_kind;
  logic                     nxt_write;
  logic [SET_W-1:0]         nxt_set;
  logic [TAG_W-1:0]         nxt_tag;
  logic [PORTS-1:0]         nxt_pvld;
  logic [PORTS*IDX_W-1:0]   nxt_psrc;
  logic [PORTS*RTAG_W-1:0]  nxt_prtag;
  logic                     byp_taken;
  logic [IDX_W-1:0]         byp_idx;
  logic [CW-1:0]            n_bank_stall;
  logic [CW-1:0]            n_mshr_stall;
  logic                     core_en;
  logic                     fill_en;

  bsched_select #(
    .NI(NI), .PORTS(PORTS), .SET_W(SET_W), .TAG_W(TAG_W), .RTAG_W(RTAG_W),
    .WRITE_BACK(WRITE_BACK), .WRITE_ACK(WRITE_ACK)
  ) u_select (
    .core_valid    (core_valid),
    .core_write    (core_write),
    .core_io       (core_io),
    .core_set      (core_set),
    .core_line_tag (core_line_tag),
    .core_rtag     (core_rtag),
    .replay_avail  (replay_avail),
    .mshr_full     (mshr_full),
    .fill_valid    (fill_valid),
    .byp_req_ready (byp_req_ready),
    .byp_rsp_valid (byp_rsp_valid),
    .byp_rsp_idx   (byp_rsp_rtag[IDX_W-1:0]),
    .core_ready    (core_ready),
    .replay_take   (replay_take),
    .fill_ready    (fill_ready),
    .nxt_kind      (nxt_kind),
    .nxt_write     (nxt_write),
    .nxt_set       (nxt_set),
    .nxt_tag       (nxt_tag),
    .nxt_pvld      (nxt_pvld),
    .nxt_psrc      (nxt_psrc),
    .nxt_prtag     (nxt_prtag),
    .byp_taken     (byp_taken),
    .byp_idx       (byp_idx),
    .n_bank_stall  (n_bank_stall),
    .n_mshr_stall  (n_mshr_stall)
  );

  bsched_byp_route #(
    .NI(NI), .SET_W(SET_W), .TAG_W(TAG_W), .RTAG_W(RTAG_W), .WRITE_ACK(WRITE_ACK)
  ) u_route (
    .core_ready    (core_ready),
    .core_write    (core_write),
    .core_io       (core_io),
    .core_set      (core_set),
    .core_line_tag (core_line_tag),
    .core_rtag     (core_rtag),
    .byp_taken     (byp_taken),
    .byp_idx       (byp_idx),
    .byp_rsp_valid (byp_rsp_valid),
    .byp_rsp_rtag  (byp_rsp_rtag),
    .byp_req_valid (byp_req_valid),
    .byp_req_write (byp_req_write),
    .byp_req_set   (byp_req_set),
    .byp_req_tag   (byp_req_tag),
    .byp_req_rtag  (byp_req_rtag),
    .rsp_valid     (rsp_valid),
    .rsp_rtag      (rsp_rtag)
  );

  bsched_satcnt #(.CNT_W(CNT_W), .INC_W(CW)) u_cnt_bank (
    .clk(clk), .rst_n(rst_n), .inc(n_bank_stall), .cnt(stall_bank_cnt)
  );

  bsched_satcnt #(.CNT_W(CNT_W), .INC_W(CW)) u_cnt_mshr (
    .clk(clk), .rst_n(rst_n), .inc(n_mshr_stall), .cnt(stall_mshr_cnt)
  );

  assign core_en = (nxt_kind == BK_CORE);
  assign fill_en = (nxt_kind == BK_FILL);

  // Registers for the bank operation. Kind and port valid bits load every
  // cycle; the payload loads only when its operation is chosen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      breq_kind     <= BK_NONE;
      breq_port_vld <= '0;
    end else begin
      breq_kind     <= nxt_kind;
      breq_port_vld <= nxt_pvld;
    end
  end

  always_ff @(posedge clk) begin
    if (core_en) begin
      breq_write <= nxt_write;
      breq_set   <= nxt_set;
      breq_tag   <= nxt_tag;
    end
    if (fill_en) begin
      breq_fill_id <= fill_id;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_slot
    always_ff @(posedge clk) begin
      if (nxt_pvld[p]) begin
        breq_port_src[p*IDX_W +: IDX_W]   <= nxt_psrc[p*IDX_W +: IDX_W];
        breq_port_rtag[p*RTAG_W +: RTAG_W] <= nxt_prtag[p*RTAG_W +: RTAG_W];
      end
    end
  end

endmodule

// File: rtl/bsched_chk.sv
module bsched_chk #(
  parameter int NI     = 4,
  parameter int PORTS  = 2,
  parameter int RTAG_W = 6,
  parameter int FID_W  = 3,
  parameter int CNT_W  = 4,
  localparam int IDX_W = $clog2(NI),
  localparam int BT_W  = RTAG_W + IDX_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NI-1:0]       core_valid,
  input logic [NI-1:0]       core_ready,
  input logic [NI-1:0]       core_write,
  input logic [NI-1:0]       core_io,
  input logic                replay_avail,
  input logic                replay_take,
  input logic                mshr_full,
  input logic                fill_valid,
  input logic [FID_W-1:0]    fill_id,
  input logic                fill_ready,
  input logic [1:0]          breq_kind,
  input logic [FID_W-1:0]    breq_fill_id,
  input logic [PORTS-1:0]    breq_port_vld,
  input logic                byp_req_valid,
  input logic                byp_rsp_valid,
  input logic [BT_W-1:0]     byp_rsp_rtag,
  input logic [NI-1:0]       rsp_valid,
  input logic [CNT_W-1:0]    stall_bank_cnt,
  input logic [CNT_W-1:0]    stall_mshr_cnt
);

  assert_replay_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    replay_avail |-> (replay_take && !fill_ready &&
                      ((core_ready & ~core_io) == '0)));

  assert_replay_issued_R1: assert property (@(posedge clk) disable iff (!rst_n)
    replay_avail |=> (breq_kind == 2'd2));

  assert_fill_issued_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!replay_avail && fill_valid) |=>
      (breq_kind == 2'd1 && breq_fill_id == $past(fill_id)));

  assert_slots_only_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (breq_kind != 2'd3) |-> (breq_port_vld == '0));

  assert_core_has_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (breq_kind == 2'd3) |-> (breq_port_vld != '0));

  assert_full_holds_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mshr_full |-> ((core_ready & core_valid & ~core_io & ~core_write) == '0));

  assert_one_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(core_ready & core_io) <= 1) &&
    (byp_req_valid == ((core_ready & core_io) != '0)));

  assert_rsp_routed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byp_rsp_valid |-> rsp_valid[byp_rsp_rtag[IDX_W-1:0]]);

  assert_bank_cnt_mono_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stall_bank_cnt >= $past(stall_bank_cnt)));

  assert_mshr_cnt_mono_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stall_mshr_cnt >= $past(stall_mshr_cnt)));

endmodule

bind bank_sched bsched_chk #(
  .NI(NI), .PORTS(PORTS), .RTAG_W(RTAG_W), .FID_W(FID_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
  .core_write(core_write), .core_io(core_io), .replay_avail(replay_avail),
  .replay_take(replay_take), .mshr_full(mshr_full), .fill_valid(fill_valid),
  .fill_id(fill_id), .fill_ready(fill_ready), .breq_kind(breq_kind),
  .breq_fill_id(breq_fill_id), .breq_port_vld(breq_port_vld),
  .byp_req_valid(byp_req_valid), .byp_rsp_valid(byp_rsp_valid),
  .byp_rsp_rtag(byp_rsp_rtag), .rsp_valid(rsp_valid),
  .stall_bank_cnt(stall_bank_cnt), .stall_mshr_cnt(stall_mshr_cnt)
);

// File: tb/sim_bank_sched.sv
module sim_bank_sched;
  localparam int NI = 4, PORTS = 2, SET_W = 3, TAG_W = 4, RTAG_W = 6;
  localparam int FID_W = 3, CNT_W = 4, IDX_W = 2, BT_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NI-1:0] core_valid, core_ready, core_write, core_io;
  logic [NI*SET_W-1:0] core_set;
  logic [NI*TAG_W-1:0] core_line_tag;
  logic [NI*RTAG_W-1:0] core_rtag;
  logic replay_avail, replay_take, mshr_full, fill_valid, fill_ready;
  logic [FID_W-1:0] fill_id, breq_fill_id;
  logic [1:0] breq_kind;
  logic breq_write;
  logic [SET_W-1:0] breq_set, byp_req_set;
  logic [TAG_W-1:0] breq_tag, byp_req_tag;
  logic [PORTS-1:0] breq_port_vld;
  logic [PORTS*IDX_W-1:0] breq_port_src;
  logic [PORTS*RTAG_W-1:0] breq_port_rtag;
  logic byp_req_valid, byp_req_ready, byp_req_write, byp_rsp_valid;
  logic [BT_W-1:0] byp_req_rtag, byp_rsp_rtag;
  logic [NI-1:0] rsp_valid;
  logic [NI*RTAG_W-1:0] rsp_rtag;
  logic [CNT_W-1:0] stall_bank_cnt, stall_mshr_cnt;

  int checks = 0, errors = 0;
  int eb = 0, em = 0;

  always #5 clk = ~clk;

  bank_sched u0 (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    core_valid = '0; core_write = '0; core_io = '0;
    core_set = '0; core_line_tag = '0; core_rtag = '0;
    replay_avail = 0; mshr_full = 0; fill_valid = 0; fill_id = '0;
    byp_req_ready = 1; byp_rsp_valid = 0; byp_rsp_rtag = '0;
  endtask

  task automatic setc(int i, bit w, bit io, int s, int t, int r);
    core_valid[i] = 1'b1; core_write[i] = w; core_io[i] = io;
    core_set[i*SET_W +: SET_W] = SET_W'(s);
    core_line_tag[i*TAG_W +: TAG_W] = TAG_W'(t);
    core_rtag[i*RTAG_W +: RTAG_W] = RTAG_W'(r);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int sat(int v);
    return (v > 15) ? 15 : v;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    #23;
    check("R12 kind", breq_kind, 0);
    check("R12 pvld", breq_port_vld, 0);
    check("R12 cnt", {stall_bank_cnt, stall_mshr_cnt}, 0);
    rst_n = 1;
    tick();

    // R1: replay beats fill and cached core; uncached still goes
    idle(); replay_avail = 1; fill_valid = 1; setc(0, 0, 0, 1, 2, 5); setc(1, 0, 1, 0, 0, 7);
    #2;
    check("R1 take/fill", {replay_take, fill_ready}, 2'b10);
    check("R1 ready", core_ready, 4'b0010);
    tick();
    check("R1 kind", breq_kind, 2);

    // R2: fill when no replay
    idle(); fill_valid = 1; fill_id = 3'd5; setc(2, 0, 0, 1, 1, 1);
    #2;
    check("R2 fill_ready", fill_ready, 1);
    check("R2 ready", core_ready, 0);
    tick();
    check("R2 kind", breq_kind, 1);
    check("R2 id", breq_fill_id, 5);

    // R3: single cached read on input 3 -> slot 1
    idle(); setc(3, 0, 0, 5, 9, 6'h21);
    #2;
    check("R3 ready", core_ready, 4'b1000);
    tick();
    check("R3 kind", breq_kind, 3);
    check("R3 line", {breq_write, breq_set, breq_tag}, {1'b0, 3'd5, 4'd9});
    check("R3 pvld", breq_port_vld, 2'b10);
    check("R3 src", breq_port_src[IDX_W +: IDX_W], 3);
    check("R3 rtag", breq_port_rtag[RTAG_W +: RTAG_W], 6'h21);

    // R4: inputs 0 and 1 same line, write -> merged
    idle(); setc(0, 1, 0, 2, 3, 6'h11); setc(1, 1, 0, 2, 3, 6'h12);
    #2;
    check("R4 ready", core_ready, 4'b0011);
    tick();
    check("R4 pvld", breq_port_vld, 2'b11);
    check("R4 rtags", breq_port_rtag, {6'h12, 6'h11});

    // R5: slot clash (2%2==0) and tag mismatch (input 1)
    idle(); setc(0, 0, 0, 2, 3, 1); setc(1, 0, 0, 2, 4, 2); setc(2, 0, 0, 2, 3, 3);
    #2;
    check("R5 ready", core_ready, 4'b0001);
    tick();
    eb = sat(eb + 2);
    check("R5 bank cnt", stall_bank_cnt, eb);
    // R5: direction mismatch
    idle(); setc(0, 0, 0, 2, 3, 1); setc(1, 1, 0, 2, 3, 2);
    #2;
    check("R5 dir ready", core_ready, 4'b0001);
    tick();
    eb = sat(eb + 1);
    check("R5 dir cnt", stall_bank_cnt, eb);

    // R6: full miss table holds read, write-through write passes
    idle(); mshr_full = 1; setc(0, 0, 0, 1, 1, 1); setc(1, 1, 0, 1, 1, 2);
    #2;
    check("R6 ready", core_ready, 4'b0010);
    tick();
    em = sat(em + 1);
    check("R6 mshr cnt", stall_mshr_cnt, em);
    check("R6 kind", {breq_kind, breq_port_vld}, {2'd3, 2'b10});

    // R7: two uncached inputs, lowest wins; tag encoding
    idle(); fill_valid = 1; setc(1, 0, 1, 3, 7, 6'h2B); setc(2, 0, 1, 4, 8, 6'h15);
    #2;
    check("R7 ready", core_ready, 4'b0010);
    check("R7 byp", {byp_req_valid, byp_req_set, byp_req_tag, byp_req_rtag},
          {1'b1, 3'd3, 4'd7, 6'h2B, 2'd1});
    tick();
    check("R7 not in bank", breq_kind, 1);
    idle(); byp_req_ready = 0; setc(1, 0, 1, 3, 7, 1);
    #2;
    check("R7 no ready", {core_ready, byp_req_valid}, 0);
    tick();

    // R8: response to input 3
    idle(); byp_rsp_valid = 1; byp_rsp_rtag = {6'h2A, 2'd3};
    #2;
    check("R8 valid", rsp_valid, 4'b1000);
    check("R8 tag", rsp_rtag[3*RTAG_W +: RTAG_W], 6'h2A);
    tick();

    // R9: uncached write acked immediately
    idle(); setc(2, 1, 1, 0, 0, 6'h33);
    #2;
    check("R9 ready", core_ready, 4'b0100);
    check("R9 ack", {rsp_valid, rsp_rtag[2*RTAG_W +: RTAG_W]}, {4'b0100, 6'h33});
    tick();

    // R10: collision with response on same lane holds the write
    idle(); setc(2, 1, 1, 0, 0, 6'h33); byp_rsp_valid = 1; byp_rsp_rtag = {6'h05, 2'd2};
    #2;
    check("R10 held", core_ready, 0);
    check("R10 lane", {rsp_valid, rsp_rtag[2*RTAG_W +: RTAG_W]}, {4'b0100, 6'h05});
    tick();
    idle(); setc(2, 0, 1, 0, 0, 6'h33); byp_rsp_valid = 1; byp_rsp_rtag = {6'h05, 2'd2};
    #2;
    check("R10 read ok", core_ready, 4'b0100);
    tick();

    // Sweep of cached patterns against a requirement-level model (R3-R6, R11)
    for (int p = 0; p < 2048; p++) begin
      logic [3:0] v, ln, w, er;
      logic [1:0] epv;
      logic ok, ew, el;
      int nb, nm;
      idle();
      v = p[3:0]; ln = p[7:4]; w = {p[9], p[8], p[9], p[8]}; mshr_full = p[10];
      for (int i = 0; i < NI; i++)
        if (v[i]) setc(i, w[i], 0, 1, ln[i] ? 4 : 3, i + 8);
      ok = 0; ew = 0; el = 0; epv = 0; er = 0; nb = 0; nm = 0;
      for (int i = 0; i < NI; i++) begin
        if (!v[i]) continue;
        if (!w[i] && mshr_full) nm++;
        else if (!ok) begin ok = 1; ew = w[i]; el = ln[i]; epv[i % 2] = 1; er[i] = 1; end
        else if (w[i] != ew || ln[i] != el || epv[i % 2]) nb++;
        else begin epv[i % 2] = 1; er[i] = 1; end
      end
      #2;
      check("R4 sweep ready", core_ready, er);
      tick();
      eb = sat(eb + nb); em = sat(em + nm);
      check("R3 sweep op", {breq_kind, breq_port_vld}, {ok ? 2'd3 : 2'd0, epv});
      check("R11 sweep cnt", {stall_bank_cnt, stall_mshr_cnt}, {4'(eb), 4'(em)});
    end

    // R11: saturation explicitly
    check("R11 sat", {stall_bank_cnt, stall_mshr_cnt}, 8'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule